// File: doc/BRIEF.md
# Synchronous Burst Bus Master

This block turns a core-side transfer request into a cycle on a synchronous external bus. A request either moves one long word or fills a four-long-word line. On the bus side the block drives an active-low start strobe in the first clock of every cycle and an active-low busy strobe for as long as the cycle lasts. It also drives a 2-bit long-word index that names the beat now on the bus. The slave closes each beat with an active-low acknowledge, an active-low error, or both together.

When acknowledge and error arrive together on the first beat, the slave is asking for a retry: the block drops the attempt and starts the same cycle again at once. The same combination on any later beat of a burst ends the burst as a failure. A one-clock done pulse with an error flag reports completion to the core. Every acknowledged read beat is returned with a one-clock valid strobe and its long-word index.

Top module: `burst_bus_master`

## Requirements
- R1: While reset is asserted and in the first clock after it, bus_start_n and bus_busy_n are high, req_ready is high, and rsp_done and rd_valid are low.
- R2: bus_start_n is low for exactly the first clock of each bus cycle, and this includes every rerun cycle. bus_busy_n is low whenever bus_start_n is low.
- R3: bus_busy_n stays low from the start clock through the clock in which the terminating response is sampled, and is high in the clock after.
- R4: A single cycle (req_burst=0) drives bus_lw = req_addr[3:2] and takes one beat. An acknowledge alone ends it with rsp_done=1 and rsp_err=0 in the next clock.
- R5: A burst (req_burst=1) takes four acknowledged beats. bus_lw starts at req_addr[3:2] and rises by one, modulo 4, after each acknowledge. rsp_done=1 with rsp_err=0 follows the fourth acknowledge. bus_addr carries bus_lw in bits 3:2 and the request address elsewhere.
- R6: A clock in which both bus_ack_n and bus_err_n are high is a wait state. The cycle continues, and bus_lw and bus_addr hold.
- R7: bus_err_n low with bus_ack_n high, on any beat, ends the cycle with rsp_done=1 and rsp_err=1. No further beats follow.
- R8: Both strobes low on the first beat of a cycle end the attempt without rsp_done or rd_valid. bus_start_n is low again in the next clock, and bus_lw returns to req_addr[3:2].
- R9: Both strobes low on beat two, three or four of a burst end the burst with rsp_done=1 and rsp_err=1. No retry follows.
- R10: Each acknowledged read beat (bus_rnw=1) gives rd_valid=1 for one clock, in the clock after the acknowledge, with rd_data equal to the bus_rdata sampled at that edge. For a write, bus_wdata is the 32-bit lane of req_wline chosen by bus_lw (lane k at bits 32k+31:32k), and rd_valid stays low.
- R11: req_ready is low while a cycle is in progress, and a request raised then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a transfer |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | AW | Byte address of the transfer |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wline | input | BEATS*DW | Write line, one lane per long word |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Cycle failed; valid with rsp_done |
| rd_valid | output | 1 | Read beat data valid |
| rd_data | output | DW | Read beat data |
| rd_lw | output | 2 | Long-word index of the read beat |
| bus_addr | output | AW | Bus address with current long-word index |
| bus_wdata | output | DW | Write data for the current beat |
| bus_rdata | input | DW | Read data from the slave |
| bus_rnw | output | 1 | 1 = read cycle |
| bus_burst | output | 1 | 1 = burst cycle |
| bus_lw | output | 2 | Long-word number within the burst |
| bus_start_n | output | 1 | Transfer start, active low |
| bus_busy_n | output | 1 | Transfer in progress, active low |
| bus_ack_n | input | 1 | Slave acknowledge, active low |
| bus_err_n | input | 1 | Slave error, active low |

## Verification
The bench builds the block with its defaults of a 32-bit address, 32-bit long words and four beats per burst. With these values the long-word index sits at address bits 3:2 and the write line is 128 bits wide, so every start index from 0 to 3 and the wrap from 3 back to 0 can be reached. The slave scripts put retries on the first beat, including back-to-back retries, and put errors and combined strobes on later beats. Wait states fall both before and between beats.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

   // What the slave strobes mean for the beat currently on the bus
   typedef enum logic [1:0] {
      OC_WAIT  = 2'd0,
      OC_BEAT  = 2'd1,
      OC_FAULT = 2'd2,
      OC_RERUN = 2'd3
   } bbm_outcome_e;

endpackage

// File: rtl/bbm_resp_decode.sv
module bbm_resp_decode
   import bbm_pkg::*;
(
   input  logic         ack_n,
   input  logic         err_n,
   input  logic         first_beat,
   output bbm_outcome_e outcome
);

   always_comb begin
      unique case ({~ack_n, ~err_n})
         2'b00:   outcome = OC_WAIT;
         2'b10:   outcome = OC_BEAT;
         2'b01:   outcome = OC_FAULT;
         default: outcome = first_beat ? OC_RERUN : OC_FAULT;
      endcase
   end

endmodule

// File: rtl/bbm_beat_ctr.sv
module bbm_beat_ctr #(
   parameter int BEATS = 4,
   parameter int LWB   = $clog2(BEATS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [LWB-1:0] load_lw,
   input  logic           advance,
   output logic [LWB-1:0] lw,
   output logic           first_beat,
   output logic           last_beat
);

   localparam logic [LWB-1:0] LAST_IDX = LWB'(BEATS - 1);

   logic [LWB-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lw    <= '0;
         idx_q <= '0;
      end else if (load) begin
         lw    <= load_lw;
         idx_q <= '0;
      end else if (advance) begin
         lw    <= lw + 1'b1;
         idx_q <= idx_q + 1'b1;
      end
   end

   assign first_beat = (idx_q == '0);
   assign last_beat  = (idx_q == LAST_IDX);

endmodule

// File: rtl/bbm_rd_path.sv
module bbm_rd_path #(
   parameter int DW  = 32,
   parameter int LWB = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           capture,
   input  logic [DW-1:0]  data_in,
   input  logic [LWB-1:0] lw_in,
   output logic           rd_valid,
   output logic [DW-1:0]  rd_data,
   output logic [LWB-1:0] rd_lw
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_lw    <= '0;
      end else begin
         rd_valid <= capture;
         if (capture) begin
            rd_data <= data_in;
            rd_lw   <= lw_in;
         end
      end
   end

endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
   import bbm_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [AW-1:0]         req_addr,
   input  logic                  req_burst,
   input  logic                  req_write,
   input  logic [BEATS*DW-1:0]   req_wline,
   output logic                  rsp_done,
   output logic                  rsp_err,
   output logic                  rd_valid,
   output logic [DW-1:0]         rd_data,
   output logic [$clog2(BEATS)-1:0] rd_lw,
   output logic [AW-1:0]         bus_addr,
   output logic [DW-1:0]         bus_wdata,
   input  logic [DW-1:0]         bus_rdata,
   output logic                  bus_rnw,
   output logic                  bus_burst,
   output logic [$clog2(BEATS)-1:0] bus_lw,
   output logic                  bus_start_n,
   output logic                  bus_busy_n,
   input  logic                  bus_ack_n,
   input  logic                  bus_err_n
);

   localparam int LWB    = $clog2(BEATS);
   localparam int LSB    = $clog2(DW / 8);
   localparam int LINE_W = BEATS * DW;

   // Elaboration-time parameter checks
   if (DW % 8 != 0) begin : g_bad_dw
      $error("burst_bus_master: DW must be a whole number of bytes");
   end
   if (BEATS < 2 || (1 << LWB) != BEATS) begin : g_bad_beats
      $error("burst_bus_master: BEATS must be a power of two, at least 2");
   end
   if (AW < LSB + LWB) begin : g_bad_aw
      $error("burst_bus_master: AW too narrow for the burst index field");
   end

   logic              busy_q;
   logic              start_q;
   logic              burst_q;
   logic              write_q;
   logic              done_q;
   logic              err_q;
   logic [AW-1:0]     addr_q;
   logic [LINE_W-1:0] line_q;

   logic              accept;
   logic              first_beat;
   logic              last_beat;
   logic              ctr_load;
   logic              ctr_advance;
   logic [LWB-1:0]    ctr_load_lw;
   logic [LWB-1:0]    lw;
   bbm_outcome_e      outcome;

   assign accept = req_valid && !busy_q;

   bbm_resp_decode u_decode (
      .ack_n      (bus_ack_n),
      .err_n      (bus_err_n),
      .first_beat (first_beat),
      .outcome    (outcome)
   );

   assign ctr_load    = accept || (busy_q && outcome == OC_RERUN);
   assign ctr_load_lw = accept ? req_addr[LSB +: LWB] : addr_q[LSB +: LWB];
   assign ctr_advance = busy_q && outcome == OC_BEAT && burst_q && !last_beat;

   bbm_beat_ctr #(
      .BEATS (BEATS),
      .LWB   (LWB)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ctr_load),
      .load_lw    (ctr_load_lw),
      .advance    (ctr_advance),
      .lw         (lw),
      .first_beat (first_beat),
      .last_beat  (last_beat)
   );

   // Control sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         burst_q <= 1'b0;
         write_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         addr_q  <= '0;
         line_q  <= '0;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
            burst_q <= req_burst;
            write_q <= req_write;
            addr_q  <= req_addr;
            line_q  <= req_wline;
         end else if (busy_q) begin
            unique case (outcome)
               OC_RERUN: start_q <= 1'b1;
               OC_FAULT: begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end
               OC_BEAT: begin
                  if (!burst_q || last_beat) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                     err_q  <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // Write line split into long-word lanes
   logic [DW-1:0] lane [BEATS];
   for (genvar g = 0; g < BEATS; g++) begin : g_lane
      assign lane[g] = line_q[g*DW +: DW];
   end

   always_comb begin
      bus_addr                = addr_q;
      bus_addr[LSB +: LWB]    = lw;
   end

   assign bus_wdata   = lane[lw];
   assign bus_lw      = lw;
   assign bus_rnw     = !write_q;
   assign bus_burst   = burst_q;
   assign bus_start_n = !start_q;
   assign bus_busy_n  = !busy_q;
   assign req_ready   = !busy_q;
   assign rsp_done    = done_q;
   assign rsp_err     = err_q;

   bbm_rd_path #(
      .DW  (DW),
      .LWB (LWB)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (busy_q && outcome == OC_BEAT && !write_q),
      .data_in  (bus_rdata),
      .lw_in    (lw),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_lw    (rd_lw)
   );

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_ready,
   input logic                     rsp_done,
   input logic                     rsp_err,
   input logic                     rd_valid,
   input logic [AW-1:0]            bus_addr,
   input logic                     bus_rnw,
   input logic                     bus_burst,
   input logic [$clog2(BEATS)-1:0] bus_lw,
   input logic                     bus_start_n,
   input logic                     bus_busy_n,
   input logic                     bus_ack_n,
   input logic                     bus_err_n
);

   localparam int LWB = $clog2(BEATS);

   // R2: start lasts one clock unless a retry is taken in that clock
   a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_start_n && !(!bus_ack_n && !bus_err_n)) |=> bus_start_n);

   // R2: start only inside a busy cycle
   a_r2_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_start_n |-> !bus_busy_n);

   // R3, R6: a wait state keeps the cycle and its address
   a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy_n && bus_ack_n && bus_err_n) |=>
         (!bus_busy_n && $stable(bus_lw) && $stable(bus_addr)));

   // R4: single cycle ends on its acknowledge
   a_r4_single_end: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy_n && !bus_burst && !bus_ack_n && bus_err_n) |=>
         (bus_busy_n && rsp_done && !rsp_err));

   // R5: an acknowledged burst beat either steps the index or ends the burst
   a_r5_lw_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy_n && bus_burst && !bus_ack_n && bus_err_n) |=>
         (bus_busy_n || bus_lw == LWB'($past(bus_lw) + 1'b1)));

   // R7: error alone ends the cycle with the error flag
   a_r7_err_end: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy_n && bus_ack_n && !bus_err_n) |=>
         (bus_busy_n && rsp_done && rsp_err));

   // R8: both strobes in the start clock restart the cycle
   a_r8_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_start_n && !bus_ack_n && !bus_err_n) |=>
         (!bus_start_n && !rsp_done && !rd_valid));

   // R10: read data follows an acknowledged read beat
   a_r10_rd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!bus_busy_n && !bus_ack_n && bus_err_n && bus_rnw));

   // R11: no new request accepted mid-cycle
   a_r11_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy_n |-> !req_ready);

endmodule

bind burst_bus_master bbm_checker #(
   .AW    (AW),
   .DW    (DW),
   .BEATS (BEATS)
) u_chk (.*);

// File: tb/burst_bus_master_bench.sv
module burst_bus_master_bench;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int BEATS = 4;
   localparam logic [31:0] RD_MASK = 32'h5A5A_C3C3;

   typedef struct {
      logic [1:0] code;   // bit0 = acknowledge, bit1 = error
      logic [1:0] lw;
   } step_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [AW-1:0]     req_addr = '0;
   logic              req_burst = 1'b0;
   logic              req_write = 1'b0;
   logic [127:0]      req_wline = '0;
   logic              rsp_done, rsp_err, rd_valid;
   logic [DW-1:0]     rd_data;
   logic [1:0]        rd_lw;
   logic [AW-1:0]     bus_addr;
   logic [DW-1:0]     bus_wdata;
   logic [DW-1:0]     bus_rdata = '0;
   logic              bus_rnw, bus_burst;
   logic [1:0]        bus_lw;
   logic              bus_start_n, bus_busy_n;
   logic              bus_ack_n = 1'b1;
   logic              bus_err_n = 1'b1;

   always #4 clk = ~clk;

   burst_bus_master #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_burst_bus_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_burst(req_burst), .req_write(req_write),
      .req_wline(req_wline), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_lw(rd_lw),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rnw(bus_rnw), .bus_burst(bus_burst), .bus_lw(bus_lw),
      .bus_start_n(bus_start_n), .bus_busy_n(bus_busy_n),
      .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n)
   );

   int     n_chk = 0;
   int     n_fail = 0;
   int     exp_starts = 0;
   int     seen_starts = 0;
   string  cur_tag = "R1";
   logic [127:0] cur_line = '0;
   logic   cur_write = 1'b0;
   step_t        script_q[$];
   logic [31:0]  exp_rd_q[$];
   logic [1:0]   exp_rdlw_q[$];
   logic         exp_done_q[$];

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Monitor (outputs) then slave (inputs), both at the falling edge
   logic prev_start = 1'b0;
   logic prev_retry = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!bus_start_n) begin
            seen_starts++;
            if (prev_start)
               chk(prev_retry, "R2 start repeated without retry", 1, 0);
         end
         if (rd_valid) begin
            if (exp_rd_q.size() == 0) chk(0, "R10 unexpected rd_valid", 1, 0);
            else begin
               chk(rd_data == exp_rd_q[0], "R10 rd_data", rd_data, exp_rd_q[0]);
               chk(rd_lw == exp_rdlw_q[0], "R10 rd_lw", rd_lw, exp_rdlw_q[0]);
               void'(exp_rd_q.pop_front());
               void'(exp_rdlw_q.pop_front());
            end
         end
         if (rsp_done) begin
            if (exp_done_q.size() == 0) chk(0, {cur_tag, " unexpected done"}, 1, 0);
            else begin
               chk(rsp_err == exp_done_q[0], {cur_tag, " rsp_err"}, rsp_err, exp_done_q[0]);
               void'(exp_done_q.pop_front());
            end
         end
      end
      prev_start = rst_n && !bus_start_n;
      prev_retry = 1'b0;
      // slave
      bus_ack_n = 1'b1;
      bus_err_n = 1'b1;
      if (rst_n && !bus_busy_n) begin
         if (script_q.size() == 0) chk(0, "R3 busy beyond scripted response", 1, 0);
         else begin
            step_t s;
            s = script_q.pop_front();
            chk(bus_lw == s.lw, {cur_tag, " bus_lw (R5/R6)"}, bus_lw, s.lw);
            chk(bus_addr[3:2] == s.lw, "R5 bus_addr index bits", bus_addr[3:2], s.lw);
            if (cur_write && s.code == 2'd1)
               chk(bus_wdata == cur_line[32*s.lw +: 32], "R10 bus_wdata lane",
                   bus_wdata, cur_line[32*s.lw +: 32]);
            bus_ack_n = !s.code[0];
            bus_err_n = !s.code[1];
            prev_retry = (s.code == 2'd3);
            bus_rdata = bus_addr ^ RD_MASK;
         end
      end
   end

   // Driver: push expectations, then issue the request
   task automatic run_txn(input string tag, input logic [31:0] addr, input bit burst,
                          input bit write, input string codes, input bit poke);
      logic [1:0] lw;
      int beat;
      bit fin;
      lw = addr[3:2];
      beat = 0;
      fin = 0;
      exp_starts++;
      cur_tag = tag;
      cur_write = write;
      cur_line = {32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000} ^ {4{addr}};
      for (int i = 0; i < codes.len() && !fin; i++) begin
         logic [1:0] c;
         step_t s;
         c = 2'(codes[i] - "0");
         s.code = c;
         s.lw = lw;
         script_q.push_back(s);
         case (c)
            2'd1: begin
               if (!write) begin
                  exp_rd_q.push_back({addr[31:4], lw, addr[1:0]} ^ RD_MASK);
                  exp_rdlw_q.push_back(lw);
               end
               if (!burst || beat == BEATS - 1) begin
                  exp_done_q.push_back(1'b0);
                  fin = 1;
               end else begin
                  beat++;
                  lw = lw + 2'd1;
               end
            end
            2'd2: begin exp_done_q.push_back(1'b1); fin = 1; end
            2'd3: begin
               if (beat == 0) begin
                  lw = addr[3:2];
                  exp_starts++;
               end else begin
                  exp_done_q.push_back(1'b1);
                  fin = 1;
               end
            end
            default: ;
         endcase
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = addr;
      req_burst = burst;
      req_write = write;
      req_wline = cur_line;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         req_valid = 1'b1;
         req_addr  = addr ^ 32'h0000_0F00;
         req_burst = 1'b0;
         @(negedge clk);
         chk(req_ready == 1'b0, "R11 req_ready during cycle", req_ready, 0);
         @(negedge clk);
         chk(req_ready == 1'b0, "R11 req_ready during cycle", req_ready, 0);
         req_valid = 1'b0;
      end
      while (exp_done_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(script_q.size() == 0, {tag, " R3 cycle ended early"}, script_q.size(), 0);
      chk(seen_starts == exp_starts, {tag, " R2/R8 start count"}, seen_starts, exp_starts);
      chk(exp_rd_q.size() == 0, {tag, " R10 missing read beats"}, exp_rd_q.size(), 0);
      chk(bus_busy_n == 1'b1 && req_ready == 1'b1, {tag, " R3 idle after done"}, bus_busy_n, 1);
   endtask

   bit ended = 0;

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_start_n && bus_busy_n, "R1 strobes high in reset", {bus_start_n, bus_busy_n}, 3);
      chk(req_ready && !rsp_done && !rd_valid, "R1 core side idle in reset",
          {req_ready, rsp_done, rd_valid}, 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_start_n && bus_busy_n && !rsp_done, "R1 idle after reset",
          {bus_start_n, bus_busy_n, rsp_done}, 6);

      run_txn("R4", 32'h1000_0008, 0, 0, "1", 0);
      run_txn("R6", 32'h2000_0004, 0, 1, "001", 0);
      run_txn("R5", 32'h3000_0000, 1, 0, "1111", 0);
      run_txn("R5", 32'h3000_0048, 1, 0, "0110011", 0);
      run_txn("R10", 32'h4000_000C, 1, 1, "1111", 0);
      run_txn("R7", 32'h5000_0000, 1, 0, "112", 0);
      run_txn("R7", 32'h5000_0104, 0, 0, "02", 0);
      run_txn("R8", 32'h6000_0008, 0, 0, "31", 0);
      run_txn("R8", 32'h6000_0014, 1, 0, "031111", 0);
      run_txn("R8", 32'h6000_002C, 1, 1, "331111", 0);
      run_txn("R9", 32'h7000_0000, 1, 0, "13", 0);
      run_txn("R9", 32'h7000_0038, 1, 0, "1113", 0);
      run_txn("R11", 32'h8000_0004, 1, 0, "0001111", 1);

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule